// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Receive Queue and Sticky Status

This block takes an asynchronous serial line and turns each frame into a byte held in a four-entry receive queue. A frame is one low start bit, eight data bits with the least significant bit first, an optional ninth bit, and a stop bit. A baud tick runs at sixteen times the bit rate, and the block samples each bit in its middle. The ninth bit is present when parity checking or extra-bit mode is on. In parity mode it is the parity bit. In extra-bit mode it is an application bit.

The host reads the queue one entry per strobe. With every byte it gets a one-bit tag from the same frame. That tag is the ninth bit when extra-bit mode is on, and the level of the first stop bit when it is off. Three sticky flags report queue overflow, a parity mismatch on the oldest queued byte, and frame completion. Each flag has its own clear strobe. Turning reception off stops new frames from being accepted, but the queue can still be read. Baud generation, interrupt logic and bus decoding live outside this block.

Top module: `serial_rx_core`

## Requirements
- R1: A frame is a low start bit, eight data bits with the least significant bit first, an optional ninth bit, and a stop bit. Each bit lasts 16 baud ticks. Each byte returned on `rd_data` equals the data bits of its frame.
- R2: The start bit is accepted only if the line stays low for half a bit (8 ticks) after the falling edge. A shorter low pulse puts nothing into the queue and does not set `done_flag`.
- R3: While `rx_en` is 0, no new frame is accepted. Bytes already in the queue can still be read, and they come out unchanged.
- R4: The queue holds 4 entries and hands them out in arrival order. `rx_full` is 1 when 4 entries are held, and `rx_empty` is 1 when none are held. The two are never 1 together.
- R5: A frame that completes while the queue is full is discarded, and `ovr_flag` is set.
- R6: `ovr_flag`, `perr_flag` and `done_flag` stay at 1 until their own clear strobe (`clr_ovr`, `clr_perr`, `clr_done`) is pulsed. If a flag is set and cleared in the same cycle, the set wins.
- R7: `done_flag` becomes 1 in the cycle after the stop bit is sampled.
- R8: With `par_en`=1, the ninth bit is a parity bit. `par_odd`=0 selects even parity (the data plus parity hold an even number of ones), and `par_odd`=1 selects odd parity. `perr_flag` is set in every cycle in which the oldest queued entry has a mismatch, so clearing it has no lasting effect until that entry has been read.
- R9: With `par_en`=0 and `xbit_en`=1, the ninth bit is received and returned on `rd_xbit` alongside its byte. With both off, there is no ninth bit and `rd_xbit` carries the stop-bit level. With `par_en`=1, `rd_xbit` carries no meaning.
- R10: A read strobe on an empty queue leaves `rd_data` and `rd_xbit` at their last values, and the queue stays empty.
- R11: After reset, the queue is empty, all three flags are 0, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | Enable pulse at 16x the bit rate |
| rx_en | input | 1 | Accept new frames when 1 |
| par_en | input | 1 | Ninth bit is a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| xbit_en | input | 1 | Ninth bit is an extra data bit |
| rd_en | input | 1 | Pop the oldest queued entry |
| clr_ovr | input | 1 | Clear the overflow flag |
| clr_perr | input | 1 | Clear the parity-error flag |
| clr_done | input | 1 | Clear the frame-complete flag |
| rd_data | output | 8 | Last byte popped |
| rd_xbit | output | 1 | Ninth-bit or stop-bit level of the last popped byte |
| rx_empty | output | 1 | Queue holds no entries |
| rx_full | output | 1 | Queue holds four entries |
| ovr_flag | output | 1 | Sticky overflow |
| perr_flag | output | 1 | Sticky parity mismatch on the oldest entry |
| done_flag | output | 1 | Sticky frame complete |

## Verification
The main path is driven with frames in four mode settings: plain eight-bit, extra-bit with the ninth bit at 0 and at 1, and parity with even and odd type, each with a correct and a wrong parity bit. These settings separate a tag taken from the stop bit from one taken from the ninth bit, and they separate the two parity senses. Data values with asymmetric bit patterns expose bit-order and shift errors. Directed sequences cover a short start glitch, filling the queue past four entries, popping an empty queue, receiving with the receiver off, and clearing the parity flag while the bad entry is still at the head.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int DATA_W     = 8;
    localparam int OVS        = 16;
    localparam int FIFO_DEPTH = 4;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              xbit;
        logic              pbad;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } rx_state_t;

    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic p,
                                        input logic odd);
        return (^{d, p}) != odd;
    endfunction

endpackage

// File: rtl/srx_deser.sv
module srx_deser
    import srx_pkg::*;
#(
    parameter int OVS_N = OVS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rxd_s,
    input  logic      tick,
    input  logic      rx_en,
    input  logic      par_en,
    input  logic      par_odd,
    input  logic      xbit_en,
    output logic      frm_valid,
    output rx_entry_t frm
);
    localparam int CW   = $clog2(OVS_N);
    localparam int HALF = OVS_N / 2;
    localparam int NW   = $clog2(DATA_W);

    rx_state_t         state;
    logic [CW-1:0]     cnt;
    logic [NW-1:0]     nbit;
    logic [DATA_W-1:0] shreg;
    logic              ninth;
    logic              has_ninth;
    logic              bit_end;

    assign has_ninth = par_en | xbit_en;
    assign bit_end   = (cnt == CW'(OVS_N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            nbit      <= '0;
            shreg     <= '0;
            ninth     <= 1'b0;
            frm_valid <= 1'b0;
            frm       <= '0;
        end else begin
            frm_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt  <= '0;
                    nbit <= '0;
                    if (rx_en && !rxd_s) state <= ST_START;
                end
                ST_START: if (tick) begin
                    if (rxd_s) begin
                        state <= ST_IDLE;
                    end else if (cnt == CW'(HALF - 1)) begin
                        cnt   <= '0;
                        state <= ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: if (tick) begin
                    if (bit_end) begin
                        cnt   <= '0;
                        shreg <= {rxd_s, shreg[DATA_W-1:1]};
                        if (nbit == NW'(DATA_W - 1)) begin
                            nbit  <= '0;
                            state <= has_ninth ? ST_NINTH : ST_STOP;
                        end else begin
                            nbit <= nbit + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_NINTH: if (tick) begin
                    if (bit_end) begin
                        cnt   <= '0;
                        ninth <= rxd_s;
                        state <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: if (tick) begin
                    if (bit_end) begin
                        cnt       <= '0;
                        state     <= ST_IDLE;
                        frm_valid <= 1'b1;
                        frm.data  <= shreg;
                        frm.xbit  <= has_ninth ? ninth : rxd_s;
                        frm.pbad  <= par_en && parity_bad(shreg, ninth, par_odd);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  rx_entry_t         din,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_xbit,
    output logic              head_pbad,
    output logic              empty,
    output logic              full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [LW-1:0] level;
    logic          do_push, do_pop;

    assign empty     = (level == '0);
    assign full      = (level == LW'(DEPTH));
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_pbad = !empty && mem[rptr].pbad;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            level   <= '0;
            rd_data <= '0;
            rd_xbit <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wptr] <= din;
                wptr      <= nxt(wptr);
            end
            if (do_pop) begin
                rd_data <= mem[rptr].data;
                rd_xbit <= mem[rptr].xbit;
                rptr    <= nxt(rptr);
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              baud_tick,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              xbit_en,
    input  logic              rd_en,
    input  logic              clr_ovr,
    input  logic              clr_perr,
    input  logic              clr_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_xbit,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              ovr_flag,
    output logic              perr_flag,
    output logic              done_flag
);
    logic [1:0] sync_q;
    logic       frm_valid;
    rx_entry_t  frm;
    logic       head_pbad;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    srx_deser #(.OVS_N(OVS)) u_deser (
        .clk(clk), .rst(rst), .rxd_s(sync_q[1]), .tick(baud_tick),
        .rx_en(rx_en), .par_en(par_en), .par_odd(par_odd), .xbit_en(xbit_en),
        .frm_valid(frm_valid), .frm(frm)
    );

    srx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(frm_valid), .din(frm), .pop(rd_en),
        .rd_data(rd_data), .rd_xbit(rd_xbit), .head_pbad(head_pbad),
        .empty(rx_empty), .full(rx_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_flag  <= 1'b0;
            perr_flag <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            ovr_flag  <= (frm_valid && rx_full) | (ovr_flag & ~clr_ovr);
            perr_flag <= (par_en && head_pbad) | (perr_flag & ~clr_perr);
            done_flag <= frm_valid | (done_flag & ~clr_done);
        end
    end
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
    input logic       clk,
    input logic       rst,
    input logic       frm_valid,
    input logic       head_pbad,
    input logic       par_en,
    input logic       rd_en,
    input logic       clr_ovr,
    input logic       clr_done,
    input logic [7:0] rd_data,
    input logic       rx_empty,
    input logic       rx_full,
    input logic       ovr_flag,
    input logic       perr_flag,
    input logic       done_flag
);
    a_r4_not_full_and_empty: assert property (@(posedge clk) disable iff (rst)
        !(rx_full && rx_empty));

    a_r5_overrun_sets_flag: assert property (@(posedge clk) disable iff (rst)
        frm_valid && rx_full |=> ovr_flag);

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        ovr_flag && !clr_ovr |=> ovr_flag);

    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done_flag && !clr_done |=> done_flag);

    a_r7_done_after_stop: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> done_flag);

    a_r8_parity_head: assert property (@(posedge clk) disable iff (rst)
        par_en && head_pbad |=> perr_flag);

    a_r10_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
        rd_en && rx_empty |=> $stable(rd_data));
endmodule

bind serial_rx_core srx_checker u_chk (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .head_pbad(head_pbad),
    .par_en(par_en), .rd_en(rd_en), .clr_ovr(clr_ovr), .clr_done(clr_done),
    .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full),
    .ovr_flag(ovr_flag), .perr_flag(perr_flag), .done_flag(done_flag)
);

// File: tb/tb_serial_rx_core.sv
module tb_serial_rx_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       baud_tick = 1'b1;
    logic       rx_en = 1'b1, par_en = 1'b0, par_odd = 1'b0, xbit_en = 1'b0;
    logic       rd_en = 1'b0, clr_ovr = 1'b0, clr_perr = 1'b0, clr_done = 1'b0;
    logic [7:0] rd_data;
    logic       rd_xbit, rx_empty, rx_full, ovr_flag, perr_flag, done_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    serial_rx_core dut (
        .clk(clk), .rst(rst), .rxd(rxd), .baud_tick(baud_tick), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .xbit_en(xbit_en), .rd_en(rd_en),
        .clr_ovr(clr_ovr), .clr_perr(clr_perr), .clr_done(clr_done),
        .rd_data(rd_data), .rd_xbit(rd_xbit), .rx_empty(rx_empty), .rx_full(rx_full),
        .ovr_flag(ovr_flag), .perr_flag(perr_flag), .done_flag(done_flag)
    );

    // vector: {par_en, par_odd, xbit_en, ninth, data[7:0]}
    localparam logic [11:0] VEC [8] = '{
        {4'b0000, 8'h55},
        {4'b0010, 8'hA3},
        {4'b0011, 8'h3C},
        {4'b1000, 8'h0F},
        {4'b1001, 8'h0F},
        {4'b1101, 8'h0F},
        {4'b1100, 8'h81},
        {4'b0000, 8'hFE}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic v);
        rxd = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic has9, input logic b9);
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) bit_out(d[i]);
        if (has9) bit_out(b9);
        bit_out(1'b1);
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_rd;
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
    endtask

    task automatic clear_all;
        clr_ovr = 1'b1; clr_perr = 1'b1; clr_done = 1'b1;
        @(negedge clk);
        clr_ovr = 1'b0; clr_perr = 1'b0; clr_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 empty", rx_empty, 1);
        chk("R11 flags", {ovr_flag, perr_flag, done_flag}, 0);
        chk("R11 rd_data", rd_data, 0);

        // table of modes: R1 R7 R8 R9
        for (int k = 0; k < 8; k++) begin
            logic [11:0] v;
            logic pe, po, xe, b9, exp_perr;
            v  = VEC[k];
            pe = v[11]; po = v[10]; xe = v[9]; b9 = v[8];
            par_en = pe; par_odd = po; xbit_en = xe;
            exp_perr = pe && ((^{v[7:0], b9}) != po);
            send(v[7:0], pe | xe, b9);
            chk("R7 done after frame", done_flag, 1);
            chk("R8 parity flag", perr_flag, exp_perr);
            pulse_rd();
            chk("R1 data", rd_data, v[7:0]);
            if (!pe) chk("R9 tag bit", rd_xbit, xe ? b9 : 1'b1);
            clear_all();
        end
        par_en = 0; par_odd = 0; xbit_en = 0;

        // R2 glitch
        rxd = 1'b0; repeat (5) @(negedge clk); rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk("R2 glitch no entry", rx_empty, 1);
        chk("R2 glitch no done", done_flag, 0);

        // R4 R5 fill and overrun
        for (int i = 0; i < 4; i++) send(8'h10 + 8'(i), 1'b0, 1'b0);
        chk("R4 full", rx_full, 1);
        chk("R5 no overrun yet", ovr_flag, 0);
        send(8'hEE, 1'b0, 1'b0);
        chk("R5 overrun set", ovr_flag, 1);
        repeat (30) @(negedge clk);
        chk("R6 overrun sticky", ovr_flag, 1);
        for (int i = 0; i < 4; i++) begin
            pulse_rd();
            chk("R4 order", rd_data, 8'h10 + 8'(i));
        end
        chk("R4 empty after drain", rx_empty, 1);
        // R10 empty read
        pulse_rd();
        chk("R10 empty read holds", rd_data, 8'h13);
        chk("R10 still empty", rx_empty, 1);
        clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0; @(negedge clk);
        chk("R6 overrun cleared", ovr_flag, 0);
        chk("R6 done still set", done_flag, 1);
        clear_all();
        chk("R6 done cleared", done_flag, 0);

        // R3 receive disabled
        rx_en = 1'b0;
        send(8'h77, 1'b0, 1'b0);
        chk("R3 disabled no entry", rx_empty, 1);
        chk("R3 disabled no done", done_flag, 0);
        rx_en = 1'b1;
        send(8'h42, 1'b0, 1'b0);
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        pulse_rd();
        chk("R3 drain while disabled", rd_data, 8'h42);
        rx_en = 1'b1;
        clear_all();

        // R8 flag re-asserts while bad entry at head
        par_en = 1'b1; par_odd = 1'b0;
        send(8'h01, 1'b1, 1'b0);
        chk("R8 bad parity flagged", perr_flag, 1);
        clr_perr = 1'b1; @(negedge clk); clr_perr = 1'b0; @(negedge clk);
        chk("R8 flag held by head", perr_flag, 1);
        pulse_rd();
        clr_perr = 1'b1; @(negedge clk); clr_perr = 1'b0; @(negedge clk);
        chk("R8 flag cleared after pop", perr_flag, 0);

        finished = 1;
        summary();
    end
endmodule